// File: doc/BRIEF.md
# Dual-Select Static RAM with Output Disable

This block is a small clocked word memory. It has a separate write-data input and read-data output, and an 8-bit word address. It stays idle unless both of its chip selects are asserted. One select is active low and the other is active high, so two address-decode lines can be combined directly without extra gating. A read/write strobe chooses between fetching a stored word and storing the input word. An output-disable input forces the output into its off state whatever the other controls are doing. That lets the output share a wire-OR bus, or a bus that is tied back to the data input.

The output pad is modelled as a data value plus an enable flag. Both are registered in the same cycle, so they always stay aligned. During a write with the output disable low, the word being written appears on the output. When the enable flag is low, the output value is zero.

Top module: `dual_sel_sram`

## Requirements
- R1: While reset is asserted, and in the cycle after it is released, `dout_oe` is 0 and `dout` is 0. With `CLEAR_ON_RESET`=1 every stored word reads back as 0 after reset.
- R2: The block is selected only when `sel_a_n`=0 and `sel_b`=1. Any other select combination is standby, and one cycle later it gives `dout_oe`=0.
- R3: `out_dis`=1 on a clock edge gives `dout_oe`=0 one cycle later, whatever the selects and `rd_wr_n` are.
- R4: A read is `sel_a_n`=0, `sel_b`=1, `out_dis`=0 and `rd_wr_n`=1. It gives `dout_oe`=1 one cycle later, with `dout` equal to the word stored at `addr`.
- R5: A write is `sel_a_n`=0, `sel_b`=1 and `rd_wr_n`=0. It stores `din` at `addr` on that clock edge, whatever the value of `out_dis`.
- R6: A write with `out_dis`=0 gives `dout_oe`=1 one cycle later, with `dout` equal to the `din` that was written.
- R7: A write with `out_dis`=1 gives `dout_oe`=0 one cycle later, and the word is still stored.
- R8: `rd_wr_n`=0 while in standby stores nothing. Contents read back later are unchanged.
- R9: Whenever `dout_oe` is 0, `dout` is 0.
- R10: A read of an address written on the previous edge returns the newly written word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W (8) | Word address |
| din | input | DATA_W (4) | Write data |
| sel_a_n | input | 1 | Chip select, active low |
| sel_b | input | 1 | Chip select, active high |
| rd_wr_n | input | 1 | 1 = read, 0 = write |
| out_dis | input | 1 | 1 forces the output off |
| dout | output | DATA_W (4) | Output data, 0 while the output is off |
| dout_oe | output | 1 | Output enable; stands in for the three-state pad |

## Verification
On every cycle the assertions check the following: the output turns off one cycle after standby or an output disable, a visible write echoes the written word, the output is on after a read, and the output value is zero while the enable is low. What a read actually returns can only be shown by the bench scenarios and its memory model. That covers data stored by a hidden write, words left untouched by standby write attempts, back-to-back write-then-read, and the contents after reset.

// File: rtl/dual_sel_sram_pkg.sv
package dual_sel_sram_pkg;

   // Access mode derived from the control inputs on each cycle
   typedef enum logic [2:0] {
      MODE_IDLE       = 3'd0,  // deselected
      MODE_MUTE_READ  = 3'd1,  // selected read, output forced off
      MODE_READ       = 3'd2,  // selected read, output on
      MODE_WRITE_SHOW = 3'd3,  // selected write, written word shown
      MODE_WRITE_MUTE = 3'd4   // selected write, output forced off
   } access_mode_e;

   function automatic logic mode_writes(access_mode_e m);
      return (m == MODE_WRITE_SHOW) || (m == MODE_WRITE_MUTE);
   endfunction

   function automatic logic mode_drives(access_mode_e m);
      return (m == MODE_READ) || (m == MODE_WRITE_SHOW);
   endfunction

endpackage

// File: rtl/dual_sel_sram_mode_dec.sv
module dual_sel_sram_mode_dec
   import dual_sel_sram_pkg::*;
(
   input  logic         sel_a_n,
   input  logic         sel_b,
   input  logic         rd_wr_n,
   input  logic         out_dis,
   output access_mode_e mode,
   output logic         wr_en,
   output logic         drive_en,
   output logic         show_din
);

   logic selected;

   always_comb begin
      selected = (sel_a_n == 1'b0) && (sel_b == 1'b1);
      if (!selected) begin
         mode = MODE_IDLE;
      end else if (rd_wr_n) begin
         mode = out_dis ? MODE_MUTE_READ : MODE_READ;
      end else begin
         mode = out_dis ? MODE_WRITE_MUTE : MODE_WRITE_SHOW;
      end
      wr_en    = mode_writes(mode);
      drive_en = mode_drives(mode);
      show_din = (mode == MODE_WRITE_SHOW);
   end

endmodule

// File: rtl/dual_sel_sram_array.sv
module dual_sel_sram_array #(
   parameter int ADDR_W         = 8,
   parameter int DATA_W         = 4,
   parameter bit CLEAR_ON_RESET = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] rd_data
);

   localparam int DEPTH = 1 << ADDR_W;

   logic [DATA_W-1:0] cells [DEPTH];

   generate
      if (CLEAR_ON_RESET) begin : g_clear
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < DEPTH; i++) begin
                  cells[i] <= '0;
               end
            end else if (wr_en) begin
               cells[addr] <= wr_data;
            end
         end
      end else begin : g_keep
         always_ff @(posedge clk) begin
            if (wr_en) begin
               cells[addr] <= wr_data;
            end
         end
      end
   endgenerate

   // Combinational read of the word currently stored
   assign rd_data = cells[addr];

endmodule

// File: rtl/dual_sel_sram_out_stage.sv
module dual_sel_sram_out_stage #(
   parameter int DATA_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              drive_en,
   input  logic              show_din,
   input  logic [DATA_W-1:0] din,
   input  logic [DATA_W-1:0] rd_data,
   output logic [DATA_W-1:0] dout,
   output logic              dout_oe
);

   logic [DATA_W-1:0] next_data;

   always_comb begin
      if (!drive_en) begin
         next_data = '0;
      end else if (show_din) begin
         next_data = din;
      end else begin
         next_data = rd_data;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dout    <= '0;
         dout_oe <= 1'b0;
      end else begin
         dout    <= next_data;
         dout_oe <= drive_en;
      end
   end

endmodule

// File: rtl/dual_sel_sram.sv
module dual_sel_sram
   import dual_sel_sram_pkg::*;
#(
   parameter int ADDR_W         = 8,
   parameter int DATA_W         = 4,
   parameter bit CLEAR_ON_RESET = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] din,
   input  logic              sel_a_n,
   input  logic              sel_b,
   input  logic              rd_wr_n,
   input  logic              out_dis,
   output logic [DATA_W-1:0] dout,
   output logic              dout_oe
);

   localparam int DEPTH = 1 << ADDR_W;

   generate
      if (ADDR_W < 1 || ADDR_W > 12) begin : g_bad_addr
         $error("dual_sel_sram: ADDR_W must be in 1..12");
      end
      if (DATA_W < 1) begin : g_bad_data
         $error("dual_sel_sram: DATA_W must be at least 1");
      end
      if (DEPTH * DATA_W > 16384) begin : g_bad_size
         $error("dual_sel_sram: array too large");
      end
   endgenerate

   access_mode_e      mode;
   logic              wr_en;
   logic              drive_en;
   logic              show_din;
   logic [DATA_W-1:0] rd_data;

   dual_sel_sram_mode_dec u_dec (
      .sel_a_n  (sel_a_n),
      .sel_b    (sel_b),
      .rd_wr_n  (rd_wr_n),
      .out_dis  (out_dis),
      .mode     (mode),
      .wr_en    (wr_en),
      .drive_en (drive_en),
      .show_din (show_din)
   );

   dual_sel_sram_array #(
      .ADDR_W         (ADDR_W),
      .DATA_W         (DATA_W),
      .CLEAR_ON_RESET (CLEAR_ON_RESET)
   ) u_array (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .addr    (addr),
      .wr_data (din),
      .rd_data (rd_data)
   );

   dual_sel_sram_out_stage #(
      .DATA_W (DATA_W)
   ) u_out (
      .clk      (clk),
      .rst_n    (rst_n),
      .drive_en (drive_en),
      .show_din (show_din),
      .din      (din),
      .rd_data  (rd_data),
      .dout     (dout),
      .dout_oe  (dout_oe)
   );

endmodule

// File: rtl/dual_sel_sram_chk.sv
module dual_sel_sram_chk #(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] addr,
   input logic [DATA_W-1:0] din,
   input logic              sel_a_n,
   input logic              sel_b,
   input logic              rd_wr_n,
   input logic              out_dis,
   input logic [DATA_W-1:0] dout,
   input logic              dout_oe
);

   logic sel_ok;
   assign sel_ok = !sel_a_n && sel_b;

   // R2
   standby_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !sel_ok |=> !dout_oe);

   // R3
   disable_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_dis |=> !dout_oe);

   // R4
   read_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_ok && rd_wr_n && !out_dis) |=> dout_oe);

   // R6
   write_echo_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_ok && !rd_wr_n && !out_dis) |=> (dout_oe && dout == $past(din)));

   // R7
   write_mute_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_ok && !rd_wr_n && out_dis) |=> !dout_oe);

   // R9
   off_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !dout_oe |-> (dout == '0));

endmodule

bind dual_sel_sram dual_sel_sram_chk #(
   .ADDR_W (ADDR_W),
   .DATA_W (DATA_W)
) chk_i (
   .clk     (clk),
   .rst_n   (rst_n),
   .addr    (addr),
   .din     (din),
   .sel_a_n (sel_a_n),
   .sel_b   (sel_b),
   .rd_wr_n (rd_wr_n),
   .out_dis (out_dis),
   .dout    (dout),
   .dout_oe (dout_oe)
);

// File: tb/dual_sel_sram_tb_top.sv
`timescale 1ns/1ps
module dual_sel_sram_tb_top;

   localparam int AW = 8;
   localparam int DW = 4;
   localparam int NW = 1 << AW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [AW-1:0] addr = '0;
   logic [DW-1:0] din = '0;
   logic          sel_a_n = 1'b1;
   logic          sel_b = 1'b0;
   logic          rd_wr_n = 1'b1;
   logic          out_dis = 1'b0;
   logic [DW-1:0] dout;
   logic          dout_oe;

   int total = 0;
   int bad = 0;
   int cycles = 0;
   bit done = 0;

   always #10 clk = ~clk;  // 50 MHz

   dual_sel_sram dut_i (
      .clk(clk), .rst_n(rst_n), .addr(addr), .din(din),
      .sel_a_n(sel_a_n), .sel_b(sel_b), .rd_wr_n(rd_wr_n),
      .out_dis(out_dis), .dout(dout), .dout_oe(dout_oe)
   );

   // Behavioural reference model
   int    ref_mem [NW];
   string ref_tag [NW];
   int    exp_dout = 0;
   int    exp_oe = 0;
   string exp_tag = "R1";
   int    last_wr_addr = -1;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < NW; i++) begin
            ref_mem[i] = 0;
            ref_tag[i] = "R1";
         end
         exp_dout = 0; exp_oe = 0; exp_tag = "R1"; last_wr_addr = -1;
      end else begin
         int a;
         bit chosen;
         a = int'(addr);
         chosen = (sel_a_n == 1'b0) && (sel_b == 1'b1);
         if (!chosen) begin
            exp_oe = 0; exp_dout = 0; exp_tag = "R2";
            if (!rd_wr_n) ref_tag[a] = "R8";
            last_wr_addr = -1;
         end else if (rd_wr_n) begin
            if (out_dis) begin
               exp_oe = 0; exp_dout = 0; exp_tag = "R3";
            end else begin
               exp_oe = 1; exp_dout = ref_mem[a];
               exp_tag = (a == last_wr_addr) ? "R10" : ref_tag[a];
            end
            last_wr_addr = -1;
         end else begin
            ref_mem[a] = int'(din);
            if (out_dis) begin
               exp_oe = 0; exp_dout = 0; exp_tag = "R7";
               ref_tag[a] = "R5";
            end else begin
               exp_oe = 1; exp_dout = int'(din); exp_tag = "R6";
               ref_tag[a] = "R4";
            end
            last_wr_addr = a;
         end
      end
   end

   task automatic check(string tag, int act, int exp, string what);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
      end
   endtask

   // Compare on every clock, away from the rising edge
   always @(negedge clk) begin
      if (rst_n && !done) begin
         check(exp_tag, int'(dout_oe), exp_oe, "dout_oe");
         check(exp_tag, int'(dout), exp_dout, "dout");
         if (!dout_oe) check("R9", int'(dout), 0, "dout while off");
      end
   end

   task automatic cyc(bit an, bit b, bit rw, bit od, int a, int d);
      sel_a_n = an; sel_b = b; rd_wr_n = rw; out_dis = od;
      addr = AW'(a); din = DW'(d);
      @(negedge clk);
   endtask

   initial begin
      @(negedge clk);
      @(negedge clk);
      // R1: outputs held off during reset
      check("R1", int'(dout_oe), 0, "dout_oe in reset");
      check("R1", int'(dout), 0, "dout in reset");
      rst_n = 1'b1;
      @(negedge clk);
      // R1: contents cleared
      for (int i = 0; i < 8; i++) cyc(0, 1, 1, 0, i * 37, 0);
      // R5/R6: visible writes across the array
      for (int i = 0; i < 32; i++) cyc(0, 1, 0, 0, i * 8, (i * 5 + 3) & 15);
      // R4: read them back
      for (int i = 0; i < 32; i++) cyc(0, 1, 1, 0, i * 8, 0);
      // R2/R8: write attempts under each standby combination
      cyc(1, 1, 0, 0, 8, 4'hA);
      cyc(0, 0, 0, 0, 16, 4'hB);
      cyc(1, 0, 0, 0, 24, 4'hC);
      cyc(1, 1, 1, 0, 32, 0);
      cyc(0, 0, 1, 1, 32, 0);
      cyc(0, 1, 1, 0, 8, 0);
      cyc(0, 1, 1, 0, 16, 0);
      cyc(0, 1, 1, 0, 24, 0);
      // R7/R5: hidden writes then visible read
      for (int i = 0; i < 8; i++) cyc(0, 1, 0, 1, 100 + i, 15 - i);
      for (int i = 0; i < 8; i++) cyc(0, 1, 1, 0, 100 + i, 0);
      // R3: output disable on a selected read and in standby
      cyc(0, 1, 1, 1, 100, 0);
      cyc(1, 0, 1, 1, 100, 0);
      cyc(0, 1, 1, 0, 100, 0);
      // R10: write then read the same address back to back
      for (int i = 0; i < 8; i++) begin
         cyc(0, 1, 0, i[0], 200 + i, i + 6);
         cyc(0, 1, 1, 0, 200 + i, 0);
      end
      // Mixed traffic from an LFSR
      begin
         logic [15:0] s;
         s = 16'hACE1;
         for (int i = 0; i < 400; i++) begin
            s = {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
            cyc(s[0] & s[1], s[2] | s[3], s[4], s[5] & s[6], int'(s[15:8]) & 8'h1F, int'(s[11:8]));
         end
      end
      cyc(1, 0, 1, 0, 0, 0);
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   // Watchdog
   always @(posedge clk) begin
      cycles++;
      if (cycles > 20000 && !done) begin
         done = 1;
         total++; bad++;
         $display("FAIL watchdog: actual=%0d expected<=%0d", cycles, 20000);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule